// File: doc/BRIEF.md
# Redundant Result Queue Checker

This block sits between a leading, speculative thread and a trailing, checking thread. The leading side pushes every retired instruction into an in-order queue, along with its result and a flag. The flag marks a result that cannot be trusted because it came from a load that missed for a long time, or from work that depends on such a load. The trailing side takes entries from the head one at a time. It re-executes each entry and reports its own result. The block then decides whether the entry may commit.

For a trusted entry, the trailing result is compared with the stored one. For a flagged entry, the stored result is not used. Instead the entry is handed to the trailing side a second time, and the two trailing results are compared with each other. Any disagreement starts a rewind, which does four things:
- the queue is emptied at once;
- both threads are told to squash;
- the run-ahead store buffer receives an invalidate pulse;
- a fixed-latency copy of architectural state from the trailing side to the leading side begins.

While that copy runs, the block neither accepts nor issues entries.

Top module: `redundant_result_queue`

## Requirements
- R1: Entries are issued to the trailing side in exactly the order they were enqueued. `issue_result` and `issue_inv` show the head entry's stored fields.
- R2: `occupancy` counts the stored entries, `full` is high when it equals DEPTH, and `empty` is high when it is 0. When the queue is full, `enq_ready` is low and an enqueue attempt leaves `occupancy` unchanged.
- R3: `issue_valid` is never high while the queue is empty. An issue is taken only in a cycle where both `issue_valid` and `trail_ready` are high.
- R4: For an entry with the flag clear (`issue_inv`=0), `trail_done` with `trail_result` equal to the stored result raises `commit` in that same cycle. A different value raises `rewind` in that cycle instead. The entry leaves the queue in either case.
- R5: An entry with the flag set is issued twice. The first issue carries `issue_copy`=0 and the second carries `issue_copy`=1. Both show the same stored fields, and the second issue is offered in the cycle after the first `trail_done`.
- R6: For a flagged entry, `commit` is raised on the second `trail_done` when both trailing results are equal, whatever the stored result is. No `commit` or `rewind` is produced on the first `trail_done`.
- R7: For a flagged entry, two trailing results that differ raise `rewind` on the second `trail_done`.
- R8: In the cycle `rewind` is high, `sbuf_inval` is also high. From the next cycle, `occupancy` is 0.
- R9: `copy_busy` rises in the cycle after `rewind` and stays high for exactly COPY_LAT cycles (8 by default). While it is high, `enq_ready` and `issue_valid` are low and enqueue attempts are dropped.
- R10: An enqueue in the same cycle as `rewind` is dropped, so `occupancy` is 0 afterwards.
- R11: After reset, `empty`=1, `full`=0, `occupancy`=0, `copy_busy`=0, `enq_ready`=1 and `issue_valid`=0.
- R12: A `trail_done` that arrives while no issued entry is awaiting a result has no effect: `commit` and `rewind` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Leading side offers a retired entry |
| enq_result | input | W | Result produced by the leading side |
| enq_inv | input | 1 | Entry result is untrusted (long miss or dependent on one) |
| enq_ready | output | 1 | Queue can take an entry this cycle |
| occupancy | output | $clog2(DEPTH)+1 | Number of stored entries |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| trail_ready | input | 1 | Trailing side can take an issue this cycle |
| issue_valid | output | 1 | Head entry offered to the trailing side |
| issue_result | output | W | Stored result of the head entry |
| issue_inv | output | 1 | Untrusted flag of the head entry |
| issue_copy | output | 1 | 0 for the first issue, 1 for the duplicate issue |
| trail_done | input | 1 | Trailing side reports a result for the issued entry |
| trail_result | input | W | Result computed by the trailing side |
| commit | output | 1 | Head entry passed its check and retires |
| rewind | output | 1 | Mismatch: flush the queue and squash both threads |
| sbuf_inval | output | 1 | Invalidate pulse to the run-ahead store buffer |
| copy_busy | output | 1 | Architectural state copy in progress |

## Verification
Three collisions are provoked on purpose. In the first, an enqueue arrives in the same cycle as the mismatch verdict; the queue must end up empty, which shows that the flush wins. In the second, enqueue attempts are held asserted across the whole copy window; `enq_ready` must stay low and the occupancy must not change. In the third, the queue is filled to DEPTH and one more enqueue is tried; occupancy must stay at DEPTH. Separately, a sweep over every fill level of a small queue alternates trusted and untrusted entries. The bench predicts each issued value, copy tag and verdict from the push order.

// File: rtl/rrq_pkg.sv
package rrq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT0 = 2'd1,
        ST_DUP   = 2'd2,
        ST_WAIT1 = 2'd3
    } chk_state_e;

    typedef struct packed {
        logic commit;
        logic mismatch;
        logic pop;
    } verdict_t;

    function automatic verdict_t judge(input logic equal);
        verdict_t v;
        v.commit   = equal;
        v.mismatch = !equal;
        v.pop      = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rrq_fifo.sv
module rrq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_result,
    input  logic          push_inv,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head_result,
    output logic          head_inv,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    logic [W:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {push_inv, push_result};
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign {head_inv, head_result} = mem[rd_ptr];
    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/rrq_compare.sv
module rrq_compare
    import rrq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          empty,
    input  logic          busy,
    input  logic [W-1:0]  head_result,
    input  logic          head_inv,
    input  logic          trail_ready,
    input  logic          trail_done,
    input  logic [W-1:0]  trail_result,
    output logic          issue_valid,
    output logic          issue_copy,
    output verdict_t      verdict
);
    chk_state_e st, st_nxt;
    logic [W-1:0] first_q;
    logic         capture;

    always_comb begin
        st_nxt      = st;
        issue_valid = 1'b0;
        issue_copy  = 1'b0;
        capture     = 1'b0;
        verdict     = '0;
        case (st)
            ST_IDLE: begin
                if (!empty && !busy) begin
                    issue_valid = 1'b1;
                    if (trail_ready) st_nxt = ST_WAIT0;
                end
            end
            ST_WAIT0: begin
                if (trail_done) begin
                    if (head_inv) begin
                        capture = 1'b1;
                        st_nxt  = ST_DUP;
                    end else begin
                        verdict = judge(trail_result == head_result);
                        st_nxt  = ST_IDLE;
                    end
                end
            end
            ST_DUP: begin
                issue_valid = 1'b1;
                issue_copy  = 1'b1;
                if (trail_ready) st_nxt = ST_WAIT1;
            end
            ST_WAIT1: begin
                if (trail_done) begin
                    verdict = judge(trail_result == first_q);
                    st_nxt  = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)          first_q <= '0;
        else if (capture) first_q <= trail_result;
    end
endmodule

// File: rtl/rrq_rewind.sv
module rrq_rewind #(
    parameter int COPY_LAT = 8,
    localparam int CW      = $clog2(COPY_LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic mismatch,
    output logic rewind,
    output logic sbuf_inval,
    output logic copy_busy
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (mismatch)       remain <= CW'(COPY_LAT);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign rewind     = mismatch;
    assign sbuf_inval = mismatch;
    assign copy_busy  = (remain != '0);
endmodule

// File: rtl/redundant_result_queue.sv
module redundant_result_queue
    import rrq_pkg::*;
#(
    parameter int W        = 32,
    parameter int DEPTH    = 512,
    parameter int COPY_LAT = 8,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_valid,
    input  logic [W-1:0]  enq_result,
    input  logic          enq_inv,
    output logic          enq_ready,
    output logic [AW:0]   occupancy,
    output logic          full,
    output logic          empty,
    input  logic          trail_ready,
    output logic          issue_valid,
    output logic [W-1:0]  issue_result,
    output logic          issue_inv,
    output logic          issue_copy,
    input  logic          trail_done,
    input  logic [W-1:0]  trail_result,
    output logic          commit,
    output logic          rewind,
    output logic          sbuf_inval,
    output logic          copy_busy
);
    verdict_t verdict;
    logic     push;

    assign enq_ready = !full && !copy_busy;
    assign push      = enq_valid && enq_ready && !verdict.mismatch;

    rrq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .push        (push),
        .push_result (enq_result),
        .push_inv    (enq_inv),
        .pop         (verdict.pop),
        .flush       (verdict.mismatch),
        .head_result (issue_result),
        .head_inv    (issue_inv),
        .count       (occupancy),
        .full        (full),
        .empty       (empty)
    );

    rrq_compare #(.W(W)) u_cmp (
        .clk          (clk),
        .rst          (rst),
        .empty        (empty),
        .busy         (copy_busy),
        .head_result  (issue_result),
        .head_inv     (issue_inv),
        .trail_ready  (trail_ready),
        .trail_done   (trail_done),
        .trail_result (trail_result),
        .issue_valid  (issue_valid),
        .issue_copy   (issue_copy),
        .verdict      (verdict)
    );

    rrq_rewind #(.COPY_LAT(COPY_LAT)) u_rew (
        .clk        (clk),
        .rst        (rst),
        .mismatch   (verdict.mismatch),
        .rewind     (rewind),
        .sbuf_inval (sbuf_inval),
        .copy_busy  (copy_busy)
    );

    assign commit = verdict.commit;
endmodule

// File: rtl/rrq_props.sv
module rrq_props #(
    parameter int DEPTH    = 512,
    parameter int COPY_LAT = 8,
    localparam int AW      = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst,
    input logic        enq_ready,
    input logic        full,
    input logic        empty,
    input logic [AW:0] occupancy,
    input logic        issue_valid,
    input logic        commit,
    input logic        rewind,
    input logic        copy_busy
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst || !copy_busy) busy_run <= '0;
        else                   busy_run <= busy_run + 1'b1;
    end

    // R2: a full queue offers no room
    a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
        full |-> !enq_ready);

    // R2: count never exceeds depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occupancy <= (AW+1)'(DEPTH));

    // R3: nothing offered from an empty queue
    a_r3_no_issue_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> !issue_valid);

    // R4: a verdict is either pass or fail
    a_r4_verdict_excl: assert property (@(posedge clk) disable iff (rst)
        !(commit && rewind));

    // R8: flush empties the queue
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (occupancy == '0) && empty);

    // R9: copy window opens after a rewind
    a_r9_busy_follows: assert property (@(posedge clk) disable iff (rst)
        rewind |=> copy_busy);

    // R9: no traffic while copying
    a_r9_quiet_busy: assert property (@(posedge clk) disable iff (rst)
        copy_busy |-> !issue_valid && !enq_ready);

    // R9: copy window length
    a_r9_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(copy_busy) |-> busy_run == 16'(COPY_LAT));
endmodule

bind redundant_result_queue rrq_props #(.DEPTH(DEPTH), .COPY_LAT(COPY_LAT)) u_props (
    .clk         (clk),
    .rst         (rst),
    .enq_ready   (enq_ready),
    .full        (full),
    .empty       (empty),
    .occupancy   (occupancy),
    .issue_valid (issue_valid),
    .commit      (commit),
    .rewind      (rewind),
    .copy_busy   (copy_busy)
);

// File: tb/test_redundant_result_queue.sv
module test_redundant_result_queue;
    localparam int W        = 8;
    localparam int DEPTH    = 4;
    localparam int COPY_LAT = 8;
    localparam int AW       = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [W-1:0]  enq_result = '0;
    logic          enq_inv = 1'b0;
    logic          enq_ready;
    logic [AW:0]   occupancy;
    logic          full, empty;
    logic          trail_ready = 1'b0;
    logic          issue_valid;
    logic [W-1:0]  issue_result;
    logic          issue_inv, issue_copy;
    logic          trail_done = 1'b0;
    logic [W-1:0]  trail_result = '0;
    logic          commit, rewind, sbuf_inval, copy_busy;

    int checks = 0;
    int errors = 0;
    logic enq_with_verdict = 1'b0;

    always #4 clk = ~clk;

    redundant_result_queue #(.W(W), .DEPTH(DEPTH), .COPY_LAT(COPY_LAT)) i_redundant_result_queue (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_result(enq_result), .enq_inv(enq_inv), .enq_ready(enq_ready),
        .occupancy(occupancy), .full(full), .empty(empty),
        .trail_ready(trail_ready), .issue_valid(issue_valid), .issue_result(issue_result),
        .issue_inv(issue_inv), .issue_copy(issue_copy),
        .trail_done(trail_done), .trail_result(trail_result),
        .commit(commit), .rewind(rewind), .sbuf_inval(sbuf_inval), .copy_busy(copy_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic push(input logic [W-1:0] val, input logic inv);
        @(negedge clk);
        enq_valid = 1'b1; enq_result = val; enq_inv = inv;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    // issue head, answer with r0 (and r1 for a flagged entry), check verdict
    task automatic consume(input logic [W-1:0] exp_val, input logic exp_inv,
                           input logic [W-1:0] r0, input logic [W-1:0] r1, input bit exp_ok);
        @(negedge clk);
        trail_ready = 1'b1;
        #1;
        chk(issue_valid == 1'b1, "R1 issue_valid", int'(issue_valid), 1);
        chk(issue_result == exp_val, "R1 order", int'(issue_result), int'(exp_val));
        chk(issue_inv == exp_inv, "R1 flag", int'(issue_inv), int'(exp_inv));
        chk(issue_copy == 1'b0, "R5 first copy tag", int'(issue_copy), 0);
        @(negedge clk);
        trail_ready = 1'b0;
        trail_done = 1'b1; trail_result = r0;
        if (!exp_inv && enq_with_verdict) begin
            enq_valid = 1'b1; enq_result = 8'h77; enq_inv = 1'b0;
        end
        #1;
        if (!exp_inv) begin
            chk(commit == exp_ok, "R4 commit", int'(commit), int'(exp_ok));
            chk(rewind == !exp_ok, "R4 rewind", int'(rewind), int'(!exp_ok));
            chk(sbuf_inval == !exp_ok, "R8 sbuf_inval", int'(sbuf_inval), int'(!exp_ok));
            @(negedge clk);
            trail_done = 1'b0; enq_valid = 1'b0;
        end else begin
            chk(!commit && !rewind, "R6 no verdict on first copy", int'({commit, rewind}), 0);
            @(negedge clk);
            trail_done = 1'b0;
            #1;
            chk(issue_valid && issue_copy, "R5 duplicate issue", int'({issue_valid, issue_copy}), 3);
            chk(issue_result == exp_val, "R5 duplicate fields", int'(issue_result), int'(exp_val));
            trail_ready = 1'b1;
            @(negedge clk);
            trail_ready = 1'b0;
            trail_done = 1'b1; trail_result = r1;
            #1;
            chk(commit == exp_ok, exp_ok ? "R6 commit" : "R7 commit", int'(commit), int'(exp_ok));
            chk(rewind == !exp_ok, exp_ok ? "R6 rewind" : "R7 rewind", int'(rewind), int'(!exp_ok));
            @(negedge clk);
            trail_done = 1'b0;
        end
    endtask

    task automatic watch_copy();
        int run = 0;
        chk(occupancy == 0, "R8 flushed", int'(occupancy), 0);
        while (copy_busy && run < 50) begin
            run++;
            enq_valid = 1'b1; enq_result = 8'h55; trail_ready = 1'b1;
            #1;
            chk(!enq_ready && !issue_valid, "R9 blocked while copying",
                int'({enq_ready, issue_valid}), 0);
            @(negedge clk);
        end
        enq_valid = 1'b0; trail_ready = 1'b0;
        chk(run == COPY_LAT, "R9 copy length", run, COPY_LAT);
        #1;
        chk(occupancy == 0, "R9 enqueue dropped while copying", int'(occupancy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(empty && !full && occupancy == 0, "R11 flags after reset", int'(occupancy), 0);
        chk(!copy_busy && enq_ready && !issue_valid, "R11 idle after reset",
            int'({copy_busy, enq_ready, issue_valid}), 2);

        // R12: stray trail_done with nothing outstanding
        @(negedge clk);
        trail_done = 1'b1; trail_result = 8'h12;
        #1;
        chk(!commit && !rewind, "R12 stray done ignored", int'({commit, rewind}), 0);
        @(negedge clk);
        trail_done = 1'b0;

        // sweep every fill level, alternating trusted / untrusted entries
        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) push(8'(n * 16 + i * 3 + 1), 1'((n + i) % 2));
            #1;
            chk(occupancy == n, "R2 occupancy", int'(occupancy), n);
            chk(full == (n == DEPTH), "R2 full", int'(full), int'(n == DEPTH));
            if (n == DEPTH) begin
                chk(!enq_ready, "R2 ready low when full", int'(enq_ready), 0);
                push(8'hEE, 1'b0);
                #1;
                chk(occupancy == DEPTH, "R2 overflow ignored", int'(occupancy), DEPTH);
            end
            for (int i = 0; i < n; i++) begin
                logic [W-1:0] v;
                logic f;
                v = 8'(n * 16 + i * 3 + 1);
                f = 1'((n + i) % 2);
                if (f) consume(v, f, ~v, ~v, 1'b1);
                else   consume(v, f, v, v, 1'b1);
                #1;
                chk(occupancy == n - i - 1, "R1 pop count", int'(occupancy), n - i - 1);
            end
            chk(empty && !issue_valid, "R3 no issue when empty", int'({empty, issue_valid}), 2);
        end

        // R4 / R8 / R9: trusted entry mismatch with a second entry waiting
        push(8'h30, 1'b0);
        push(8'h31, 1'b0);
        consume(8'h30, 1'b0, 8'h31, 8'h31, 1'b0);
        watch_copy();

        // R7: untrusted entry, duplicates disagree
        push(8'h40, 1'b1);
        consume(8'h40, 1'b1, 8'h05, 8'h06, 1'b0);
        watch_copy();

        // R10: enqueue coincides with mismatch
        push(8'h50, 1'b0);
        enq_with_verdict = 1'b1;
        consume(8'h50, 1'b0, 8'h51, 8'h51, 1'b0);
        enq_with_verdict = 1'b0;
        #1;
        chk(occupancy == 0, "R10 coincident enqueue dropped", int'(occupancy), 0);
        watch_copy();

        // control: enqueue alongside a passing verdict is kept (R10 contrast)
        push(8'h60, 1'b0);
        enq_with_verdict = 1'b1;
        consume(8'h60, 1'b0, 8'h60, 8'h60, 1'b1);
        enq_with_verdict = 1'b0;
        #1;
        chk(occupancy == 1, "R10 enqueue kept on pass", int'(occupancy), 1);
        consume(8'h77, 1'b0, 8'h77, 8'h77, 1'b1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule